// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by combining two independent predictors and a chooser. The first predictor is a table of 2-bit saturating counters indexed directly by the branch address. The second is a two-level scheme. A small file of per-branch-group outcome histories supplies a history, and that history (optionally XORed with address bits) indexes a pattern table of 2-bit counters. A third table of 2-bit chooser counters, indexed by address, decides which of the two answers becomes the final prediction.

The lookup port is purely combinational. It takes a branch address and returns the final direction together with both component directions. The pipeline carries the component directions to commit and hands them back on the update port with the resolved outcome. All table and history writes happen at that commit-time update, on the clock edge where the update is valid. Every table size is a power of two. The address is taken as a word address (byte address shifted right by two), reduced modulo each table's size.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every 2-bit counter (address table, pattern table, chooser table) holds 1 (weakly not-taken) and every history is zero, so each lookup returns not-taken on all three direction outputs.
- R2: The address-table counter used for PC is entry ((PC >> 2) mod BIM_ENTRIES). A counter value of 2 or 3 gives taken, and 0 or 1 gives not-taken.
- R3: On an update, the addressed counters move one step toward the outcome (+1 if taken, -1 if not) and saturate at 0 and 3.
- R4: The history used for PC is entry ((PC >> 2) mod L1_ENTRIES) of the history file. On an update it shifts left by one and takes the outcome in bit 0 (1 = taken), keeping HIST_W bits.
- R5: The pattern-table index is the history zero-extended to the index width. When XOR_EN is 1, that value is XORed with ((PC >> 2) mod L2_ENTRIES). The index is formed from the history held before the update's shift.
- R6: The chooser counter for PC is entry ((PC >> 2) mod META_ENTRIES). A value of 2 or 3 selects the two-level direction, and 0 or 1 selects the address-table direction.
- R7: The chooser counter changes only when the supplied component directions differ. It counts up when the two-level direction matched the outcome and down when the address-table direction did.
- R8: No state changes when upd_valid is 0. A lookup in the same cycle as an update sees the state from before that update.
- R9: The final direction always equals one of the two component directions presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Final predicted direction (1 = taken) |
| lk_bim_taken | output | 1 | Address-table component direction |
| lk_hist_taken | output | 1 | Two-level component direction |
| upd_valid | input | 1 | Commit-time update strobe |
| upd_pc | input | PC_W | Address of the committing branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |
| upd_bim_taken | input | 1 | Address-table direction given at lookup |
| upd_hist_taken | input | 1 | Two-level direction given at lookup |

## Verification
The bench trains one branch into both saturation limits. A counter that wrapped, or never left the weak state, would flip the prediction too early or too late. An alternating branch checks that the outcome enters history bit 0 and that the pattern index is the XORed value. A reversed shift or a missing XOR would spread the learning across the wrong entries, and the chooser would then never move to the two-level side. Aliased addresses check the modulo indexing. Updates with agreeing or forced-disagreeing component directions check that the chooser moves only on disagreement and in the right sense, and idle cycles with noise on the update inputs would expose writes that ignore the strobe.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_WEAK_NT = 2'd1;

   function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
      ctr2_t r;
      if (up) r = (c == 2'd3) ? c : c + 2'd1;
      else    r = (c == 2'd0) ? c : c - 2'd1;
      return r;
   endfunction

   function automatic logic ctr_dir(input ctr2_t c);
      return c[1];
   endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_pkg::*;
#(
   parameter int ENTRIES = 1024,
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_taken,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_up
);

   ctr2_t tbl_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_WEAK_NT;
      end else if (wr_en) begin
         tbl_q[wr_idx] <= ctr_step(tbl_q[wr_idx], wr_up);
      end
   end

   assign rd_taken = ctr_dir(tbl_q[rd_idx]);

endmodule

// File: rtl/bp_hist_file.sv
module bp_hist_file #(
   parameter int ENTRIES = 1,
   parameter int W       = 8,
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx_a,
   output logic [W-1:0]  rd_hist_a,
   input  logic [IW-1:0] rd_idx_b,
   output logic [W-1:0]  rd_hist_b,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_bit
);

   logic [W-1:0] hist_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
      end else if (wr_en) begin
         hist_q[wr_idx] <= {hist_q[wr_idx][W-2:0], wr_bit};
      end
   end

   assign rd_hist_a = hist_q[rd_idx_a];
   assign rd_hist_b = hist_q[rd_idx_b];

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
   parameter int PC_W         = 32,
   parameter int BIM_ENTRIES  = 2048,
   parameter int L1_ENTRIES   = 1,
   parameter int L2_ENTRIES   = 1024,
   parameter int HIST_W       = 8,
   parameter bit XOR_EN       = 1'b0,
   parameter int META_ENTRIES = 1024
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   output logic            lk_bim_taken,
   output logic            lk_hist_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic            upd_bim_taken,
   input  logic            upd_hist_taken
);

   localparam int BIM_IW  = (BIM_ENTRIES  > 1) ? $clog2(BIM_ENTRIES)  : 1;
   localparam int L1_IW   = (L1_ENTRIES   > 1) ? $clog2(L1_ENTRIES)   : 1;
   localparam int L2_IW   = (L2_ENTRIES   > 1) ? $clog2(L2_ENTRIES)   : 1;
   localparam int META_IW = (META_ENTRIES > 1) ? $clog2(META_ENTRIES) : 1;

   // elaboration-time parameter checks
   if ((BIM_ENTRIES & (BIM_ENTRIES - 1)) != 0 || BIM_ENTRIES < 1)
      $error("BIM_ENTRIES must be a power of two");
   if ((L1_ENTRIES & (L1_ENTRIES - 1)) != 0 || L1_ENTRIES < 1)
      $error("L1_ENTRIES must be a power of two");
   if ((L2_ENTRIES & (L2_ENTRIES - 1)) != 0 || L2_ENTRIES < 2)
      $error("L2_ENTRIES must be a power of two of at least 2");
   if ((META_ENTRIES & (META_ENTRIES - 1)) != 0 || META_ENTRIES < 1)
      $error("META_ENTRIES must be a power of two");
   if (HIST_W < 2 || HIST_W > L2_IW)
      $error("HIST_W must lie between 2 and the pattern index width");
   if (PC_W < 3)
      $error("PC_W too narrow");

   // word addresses
   logic [PC_W-1:0] lk_word, upd_word;
   assign lk_word  = lk_pc  >> 2;
   assign upd_word = upd_pc >> 2;

   // per-table indices
   logic [BIM_IW-1:0]  lk_bim_idx,  upd_bim_idx;
   logic [L1_IW-1:0]   lk_l1_idx,   upd_l1_idx;
   logic [L2_IW-1:0]   lk_l2_idx,   upd_l2_idx;
   logic [META_IW-1:0] lk_meta_idx, upd_meta_idx;
   logic [HIST_W-1:0]  lk_hist,     upd_hist;

   assign lk_bim_idx   = BIM_IW'(lk_word   & PC_W'(BIM_ENTRIES - 1));
   assign upd_bim_idx  = BIM_IW'(upd_word  & PC_W'(BIM_ENTRIES - 1));
   assign lk_l1_idx    = L1_IW'(lk_word    & PC_W'(L1_ENTRIES - 1));
   assign upd_l1_idx   = L1_IW'(upd_word   & PC_W'(L1_ENTRIES - 1));
   assign lk_meta_idx  = META_IW'(lk_word  & PC_W'(META_ENTRIES - 1));
   assign upd_meta_idx = META_IW'(upd_word & PC_W'(META_ENTRIES - 1));

   // second-level index variant
   if (XOR_EN) begin : g_l2_xor
      assign lk_l2_idx  = L2_IW'(lk_hist)  ^ L2_IW'(lk_word  & PC_W'(L2_ENTRIES - 1));
      assign upd_l2_idx = L2_IW'(upd_hist) ^ L2_IW'(upd_word & PC_W'(L2_ENTRIES - 1));
   end else begin : g_l2_plain
      assign lk_l2_idx  = L2_IW'(lk_hist);
      assign upd_l2_idx = L2_IW'(upd_hist);
   end

   logic meta_pick_hist;
   logic meta_wr_en;
   assign meta_wr_en = upd_valid && (upd_bim_taken != upd_hist_taken);

   bp_ctr_table #(.ENTRIES(BIM_ENTRIES)) u_bim (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_bim_idx),
      .rd_taken (lk_bim_taken),
      .wr_en    (upd_valid),
      .wr_idx   (upd_bim_idx),
      .wr_up    (upd_taken)
   );

   bp_hist_file #(.ENTRIES(L1_ENTRIES), .W(HIST_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx_a  (lk_l1_idx),
      .rd_hist_a (lk_hist),
      .rd_idx_b  (upd_l1_idx),
      .rd_hist_b (upd_hist),
      .wr_en     (upd_valid),
      .wr_idx    (upd_l1_idx),
      .wr_bit    (upd_taken)
   );

   bp_ctr_table #(.ENTRIES(L2_ENTRIES)) u_pht (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_l2_idx),
      .rd_taken (lk_hist_taken),
      .wr_en    (upd_valid),
      .wr_idx   (upd_l2_idx),
      .wr_up    (upd_taken)
   );

   bp_ctr_table #(.ENTRIES(META_ENTRIES)) u_meta (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_meta_idx),
      .rd_taken (meta_pick_hist),
      .wr_en    (meta_wr_en),
      .wr_idx   (upd_meta_idx),
      .wr_up    (upd_hist_taken == upd_taken)
   );

   assign lk_taken = meta_pick_hist ? lk_hist_taken : lk_bim_taken;

endmodule

// File: rtl/tourney_predictor_chk.sv
module tourney_predictor_chk #(
   parameter int PC_W   = 32,
   parameter int HIST_W = 8,
   parameter int L1_IW  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PC_W-1:0]   lk_pc,
   input logic              lk_taken,
   input logic              lk_bim_taken,
   input logic              lk_hist_taken,
   input logic              upd_valid,
   input logic [PC_W-1:0]   upd_pc,
   input logic              upd_taken,
   input logic [L1_IW-1:0]  upd_l1_idx,
   input logic [HIST_W-1:0] upd_hist
);

   // R9: final direction is one of the component directions
   a_r9_choice_is_component: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_taken == lk_bim_taken) || (lk_taken == lk_hist_taken));

   // R8: with no update, an unchanged lookup address gives unchanged outputs
   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> ($stable(lk_pc) ->
         ($stable(lk_taken) && $stable(lk_bim_taken) && $stable(lk_hist_taken))));

   // R4: history of the updated group shifts the outcome into bit 0
   a_r4_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> ((upd_l1_idx == $past(upd_l1_idx)) ->
         (upd_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)})));

   // R3: a taken update cannot turn a taken address-table prediction to not-taken
   a_r3_bim_keeps_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && lk_bim_taken && (lk_pc == upd_pc))
      |=> ($stable(lk_pc) -> lk_bim_taken));

   // R3: a not-taken update cannot turn a not-taken prediction to taken
   a_r3_bim_keeps_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && !lk_bim_taken && (lk_pc == upd_pc))
      |=> ($stable(lk_pc) -> !lk_bim_taken));

endmodule

bind tourney_predictor tourney_predictor_chk #(
   .PC_W   (PC_W),
   .HIST_W (HIST_W),
   .L1_IW  (L1_IW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_pc         (lk_pc),
   .lk_taken      (lk_taken),
   .lk_bim_taken  (lk_bim_taken),
   .lk_hist_taken (lk_hist_taken),
   .upd_valid     (upd_valid),
   .upd_pc        (upd_pc),
   .upd_taken     (upd_taken),
   .upd_l1_idx    (upd_l1_idx),
   .upd_hist      (upd_hist)
);

// File: tb/sim_tourney_predictor.sv
`timescale 1ns/1ps
module sim_tourney_predictor;

   localparam int BIMN  = 64;
   localparam int L1N   = 4;
   localparam int L2N   = 256;
   localparam int HW    = 8;
   localparam int METAN = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken, lk_bim_taken, lk_hist_taken;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic        upd_bim_taken = 1'b0;
   logic        upd_hist_taken = 1'b0;

   always #2 clk = ~clk;

   tourney_predictor #(
      .PC_W(32), .BIM_ENTRIES(BIMN), .L1_ENTRIES(L1N), .L2_ENTRIES(L2N),
      .HIST_W(HW), .XOR_EN(1'b1), .META_ENTRIES(METAN)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .lk_bim_taken(lk_bim_taken), .lk_hist_taken(lk_hist_taken),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
      .upd_bim_taken(upd_bim_taken), .upd_hist_taken(upd_hist_taken)
   );

   // behavioural reference state
   int m_bim [BIMN];
   int m_pht [L2N];
   int m_meta[METAN];
   int m_hist[L1N];

   int vectors = 0;
   int errors  = 0;
   bit finished = 0;

   function automatic int widx(input logic [31:0] pc, input int n);
      return int'((pc >> 2) % n);
   endfunction

   function automatic int l2_of(input logic [31:0] pc);
      return (m_hist[widx(pc, L1N)] ^ widx(pc, L2N)) % L2N;
   endfunction

   function automatic bit exp_bim(input logic [31:0] pc);
      return m_bim[widx(pc, BIMN)] >= 2;
   endfunction

   function automatic bit exp_two(input logic [31:0] pc);
      return m_pht[l2_of(pc)] >= 2;
   endfunction

   function automatic bit exp_final(input logic [31:0] pc);
      return (m_meta[widx(pc, METAN)] >= 2) ? exp_two(pc) : exp_bim(pc);
   endfunction

   function automatic int sat(input int c, input bit up);
      if (up) return (c < 3) ? c + 1 : 3;
      return (c > 0) ? c - 1 : 0;
   endfunction

   task automatic model_reset();
      foreach (m_bim[i])  m_bim[i]  = 1;
      foreach (m_pht[i])  m_pht[i]  = 1;
      foreach (m_meta[i]) m_meta[i] = 1;
      foreach (m_hist[i]) m_hist[i] = 0;
   endtask

   task automatic model_update(input logic [31:0] pc, input bit t, input bit bv, input bit hv);
      int bi, pi, mi, li;
      bi = widx(pc, BIMN);
      pi = l2_of(pc);
      mi = widx(pc, METAN);
      li = widx(pc, L1N);
      m_bim[bi] = sat(m_bim[bi], t);
      m_pht[pi] = sat(m_pht[pi], t);
      if (bv != hv) m_meta[mi] = sat(m_meta[mi], hv == t);
      m_hist[li] = ((m_hist[li] << 1) | int'(t)) % (1 << HW);
   endtask

   task automatic check(input bit act, input bit exp, input string what);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare lookup, model update at posedge
   task automatic cycle(input logic [31:0] lpc, input bit v, input logic [31:0] upc,
                        input bit t, input bit bv, input bit hv, input string tag);
      bit eb, eh, ef;
      @(negedge clk);
      lk_pc = lpc; upd_valid = v; upd_pc = upc;
      upd_taken = t; upd_bim_taken = bv; upd_hist_taken = hv;
      #1;
      eb = exp_bim(lpc); eh = exp_two(lpc); ef = exp_final(lpc);
      check(lk_bim_taken,  eb, {tag, " R2/R3 address-table direction"});
      check(lk_hist_taken, eh, {tag, " R4/R5 two-level direction"});
      check(lk_taken,      ef, {tag, " R6/R7 final direction"});
      check(lk_taken == lk_bim_taken || lk_taken == lk_hist_taken, 1'b1,
            {tag, " R9 final is a component"});
      @(posedge clk);
      if (v) model_update(upc, t, bv, hv);
   endtask

   // lookup and commit the same branch, component directions from the model
   task automatic train(input logic [31:0] pc, input bit t, input string tag);
      cycle(pc, 1'b1, pc, t, exp_bim(pc), exp_two(pc), tag);
   endtask

   initial begin
      logic [31:0] pool [8];
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state, no updates
      for (int i = 0; i < 6; i++)
         cycle(32'(i * 52), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1 reset");

      // R3: saturation in both directions
      for (int i = 0; i < 6; i++) train(32'h40, 1'b1, "R3 up");
      for (int i = 0; i < 6; i++) train(32'h40, 1'b0, "R3 down");
      for (int i = 0; i < 3; i++) train(32'h40, 1'b1, "R3 recover");

      // R4/R5: alternating branch learned through history
      for (int i = 0; i < 60; i++) train(32'h80, 1'(i % 2), "R4 alternate");
      for (int i = 0; i < 40; i++) train(32'h84, 1'(i % 3 == 0), "R5 period3");

      // R8: noise on update inputs with strobe low, plus same-cycle lookup
      for (int i = 0; i < 50; i++)
         cycle(32'h80, 1'b0, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), "R8 idle");
      for (int i = 0; i < 10; i++) train(32'h80, 1'b1, "R8 same-cycle");

      // R2: aliasing in the address table (stride of BIMN words)
      for (int i = 0; i < 8; i++) train(32'h100, 1'b1, "R2 alias a");
      for (int i = 0; i < 4; i++)
         cycle(32'h100 + 32'(BIMN * 4), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2 alias b");

      // R7: forced component directions, agreeing and disagreeing
      for (int i = 0; i < 200; i++)
         cycle(32'h200, 1'b1, 32'h200, 1'($urandom), 1'($urandom), 1'($urandom), "R7 chooser");

      // R6: mixed traffic over a small address pool
      for (int k = 0; k < 8; k++) pool[k] = 32'($urandom % 4096) & 32'hFFFF_FFFC;
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, b;
         a = pool[$urandom % 8];
         b = pool[$urandom % 8];
         if ($urandom % 4 == 0)
            cycle(a, 1'($urandom % 5 != 0), b, 1'($urandom), 1'($urandom), 1'($urandom), "R6 mixed");
         else
            cycle(a, 1'($urandom % 5 != 0), a, 1'(($urandom % 4) != 0), exp_bim(a), exp_two(a), "R6 trained");
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule